// File: doc/BRIEF.md
# ADC Control and Result Register Interface

This block sits between a simple register bus and an external analog-to-digital converter with a 10-bit result. It holds two writable registers. The setup register selects the input channel and the reference source, and picks the alignment of the result. The control register enables the converter, starts conversions, arms automatic triggering from an event input, enables the interrupt and selects a clock divider code. The block sends the channel, reference and divider codes straight to the converter and its clock circuit. It issues a one-cycle start pulse and tracks the conversion until the converter reports that it is done.

The finished result is read as two bytes. The result is stored raw and is aligned for reading with the current alignment bit. A read of the low byte freezes the stored result until the high byte is read, so the two halves always belong to the same conversion. A conversion that ends while the result is frozen still raises the completion flag, but its data is dropped. The completion flag drives an interrupt output when the interrupt is enabled. Software clears the flag by writing 1 to it.

Top module: `adc_regif`

## Requirements
- R1: After reset, all four addresses read 0, and `cnv_start`, `irq`, `cnv_chan`, `cnv_ref` and `clk_div_sel` are 0.
- R2: Address 0 is the setup register. Bits 7:6 are the reference code and drive `cnv_ref`. Bit 5 is the left-align bit. Bits 3:0 are the channel code and drive `cnv_chan`. Bit 4 always reads 0. The register reads back what was written, except bit 4.
- R3: Address 1 is the control register. Bit 7 is enable, bit 6 is start/busy, bit 5 is auto-trigger, bit 4 is the completion flag, bit 3 is interrupt enable and bits 2:0 are the divider code. Bits 7, 5, 3 and 2:0 read back as written, and bits 2:0 drive `clk_div_sel`.
- R4: A write to address 1 with bits 7 and 6 both set while idle makes `cnv_start` high for exactly the one cycle after the write. Bit 6 then reads 1 until the converter pulses `cnv_done`.
- R5: A start request has no effect when the written value has bit 7 at 0. A trigger edge has no effect when the stored enable bit is 0.
- R6: With enable and auto-trigger stored, a rising edge on `trig_evt` makes `cnv_start` high in the following cycle.
- R7: A start write or a trigger edge that arrives while a conversion is busy produces no `cnv_start` pulse.
- R8: `cnv_done` while busy sets the flag (bit 4). `cnv_done` while idle does nothing. Writing 1 to bit 4 clears the flag, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when the interrupt enable bit and the flag are both 1.
- R10: With left-align at 0, address 2 reads result bits 7:0. Address 3 reads result bits 9:8 in its bits 1:0, and its upper six bits read 0.
- R11: With left-align at 1, address 3 reads result bits 9:2. Address 2 reads result bits 1:0 in its bits 7:6, and its lower six bits read 0.
- R12: After a read of address 2, completed conversions do not change either byte until address 3 is read, and they still set the flag. The first conversion that completes after the unlock updates both bytes.
- R13: A conversion that completes in the same cycle as a read of address 2 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reads of addresses 2 and 3 have side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| trig_evt | input | 1 | Auto-trigger event input, synchronous to `clk` |
| cnv_start | output | 1 | One-cycle start pulse to the converter |
| cnv_done | input | 1 | Converter end-of-conversion pulse |
| cnv_data | input | RES_W | Converter result, valid with `cnv_done` |
| cnv_chan | output | 4 | Channel select to the converter |
| cnv_ref | output | 2 | Reference select to the converter |
| clk_div_sel | output | 3 | Divider code to the converter clock circuit |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- the start pulse lasts one cycle;
- a start never happens while disabled or busy;
- busy drops after a completion;
- the flag only rises on a real completion;
- the interrupt never rises without the flag;
- the stored result never changes while it is frozen.

Other behaviour needs the bench's scenarios:
- the exact bit layout of both alignments over every 10-bit result value;
- the readback of every setup byte;
- the order of freeze, drop and unlock over a sequence of reads;
- a completion that collides with a low-byte read.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;
  localparam int WORD_W = 16;

  localparam logic [ADDR_W-1:0] ADR_SETUP = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_RLO   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_RHI   = 2'd3;

  localparam int CB_EN   = 7;
  localparam int CB_GO   = 6;
  localparam int CB_AUTO = 5;
  localparam int CB_FLAG = 4;
  localparam int CB_IE   = 3;

  localparam logic [BUS_W-1:0] SETUP_MASK = 8'hEF;
  localparam logic [BUS_W-1:0] CTRL_KEEP  = 8'hAF;

  localparam int SB_LEFT = 5;

  // Align a raw result of `width` bits inside a 16-bit word.
  function automatic logic [WORD_W-1:0] align_word(input logic [WORD_W-1:0] raw,
                                                   input int unsigned width,
                                                   input logic left);
    logic [WORD_W-1:0] w;
    w = raw;
    if (left) w = raw << (WORD_W - width);
    return w;
  endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_setup,
  input  logic             wr_ctrl,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] setup_q,
  output logic [BUS_W-1:0] ctrl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_setup) setup_q <= wdata & SETUP_MASK;
      if (wr_ctrl)  ctrl_q  <= wdata & CTRL_KEEP;
    end
  end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_en_bit,
  input  logic wr_go_bit,
  input  logic wr_flag_bit,
  input  logic en,
  input  logic auto_trig,
  input  logic trig_evt,
  input  logic cnv_done,
  output logic busy,
  output logic flag,
  output logic cnv_start,
  output logic start_req,
  output logic done_ev
);

  logic trig_q;
  logic trig_edge;
  logic sw_req;
  logic hw_req;

  assign trig_edge = trig_evt & ~trig_q;
  assign sw_req    = wr_ctrl & wr_en_bit & wr_go_bit;
  assign hw_req    = en & auto_trig & trig_edge;
  assign start_req = (sw_req | hw_req) & ~busy;
  assign done_ev   = busy & cnv_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q    <= 1'b0;
      busy      <= 1'b0;
      flag      <= 1'b0;
      cnv_start <= 1'b0;
    end else begin
      trig_q    <= trig_evt;
      cnv_start <= start_req;
      if (start_req)    busy <= 1'b1;
      else if (done_ev) busy <= 1'b0;
      if (done_ev)                        flag <= 1'b1;
      else if (wr_ctrl && wr_flag_bit)    flag <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock
  import adc_regif_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_ev,
  input  logic [RES_W-1:0] cnv_data,
  input  logic             rd_lo,
  input  logic             rd_hi,
  input  logic             left,
  output logic [RES_W-1:0] res_raw,
  output logic             locked,
  output logic             capture,
  output logic [BUS_W-1:0] lo_byte,
  output logic [BUS_W-1:0] hi_byte
);

  localparam int PAD_W = WORD_W - RES_W;

  logic [WORD_W-1:0] word;

  assign capture = done_ev & ~locked & ~rd_lo;
  assign word    = align_word({{PAD_W{1'b0}}, res_raw}, RES_W, left);
  assign lo_byte = word[BUS_W-1:0];
  assign hi_byte = word[WORD_W-1:BUS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_raw <= '0;
      locked  <= 1'b0;
    end else begin
      if (capture) res_raw <= cnv_data;
      if (rd_hi)      locked <= 1'b0;
      else if (rd_lo) locked <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              trig_evt,
  output logic              cnv_start,
  input  logic              cnv_done,
  input  logic [RES_W-1:0]  cnv_data,
  output logic [3:0]        cnv_chan,
  output logic [1:0]        cnv_ref,
  output logic [2:0]        clk_div_sel,
  output logic              irq
);

  logic             wr_setup, wr_ctrl, rd_lo, rd_hi;
  logic [BUS_W-1:0] setup_q, ctrl_q;
  logic             busy, flag, start_req, done_ev;
  logic             res_locked, capture;
  logic [RES_W-1:0] res_raw;
  logic [BUS_W-1:0] lo_byte, hi_byte;
  logic             ctrl_en;

  assign wr_setup = bus_sel & bus_wr & (bus_addr == ADR_SETUP);
  assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == ADR_CTRL);
  assign rd_lo    = bus_sel & bus_rd & (bus_addr == ADR_RLO);
  assign rd_hi    = bus_sel & bus_rd & (bus_addr == ADR_RHI);

  adc_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_setup (wr_setup),
    .wr_ctrl  (wr_ctrl),
    .wdata    (bus_wdata),
    .setup_q  (setup_q),
    .ctrl_q   (ctrl_q)
  );

  assign ctrl_en = ctrl_q[CB_EN];

  adc_conv_ctrl u_conv (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wr_en_bit   (bus_wdata[CB_EN]),
    .wr_go_bit   (bus_wdata[CB_GO]),
    .wr_flag_bit (bus_wdata[CB_FLAG]),
    .en          (ctrl_en),
    .auto_trig   (ctrl_q[CB_AUTO]),
    .trig_evt    (trig_evt),
    .cnv_done    (cnv_done),
    .busy        (busy),
    .flag        (flag),
    .cnv_start   (cnv_start),
    .start_req   (start_req),
    .done_ev     (done_ev)
  );

  adc_result_lock #(.RES_W(RES_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_ev  (done_ev),
    .cnv_data (cnv_data),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .left     (setup_q[SB_LEFT]),
    .res_raw  (res_raw),
    .locked   (res_locked),
    .capture  (capture),
    .lo_byte  (lo_byte),
    .hi_byte  (hi_byte)
  );

  assign cnv_chan    = setup_q[3:0];
  assign cnv_ref     = setup_q[7:6];
  assign clk_div_sel = ctrl_q[2:0];
  assign irq         = ctrl_q[CB_IE] & flag;

  always_comb begin
    unique case (bus_addr)
      ADR_SETUP: bus_rdata = setup_q;
      ADR_CTRL:  bus_rdata = ctrl_q | (BUS_W'(busy) << CB_GO) | (BUS_W'(flag) << CB_FLAG);
      ADR_RLO:   bus_rdata = lo_byte;
      default:   bus_rdata = hi_byte;
    endcase
  end

endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv_start,
  input logic             cnv_done,
  input logic             busy,
  input logic             en,
  input logic             locked,
  input logic [RES_W-1:0] res_raw,
  input logic             flag,
  input logic             irq
);

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start);

  p_busy_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnv_done) |=> !busy);

  p_start_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> en);

  p_no_restart_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> !$past(busy));

  p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(busy && cnv_done));

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  p_frozen_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(res_raw));

endmodule

bind adc_regif adc_regif_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnv_start (cnv_start),
  .cnv_done  (cnv_done),
  .busy      (busy),
  .en        (ctrl_en),
  .locked    (res_locked),
  .res_raw   (res_raw),
  .flag      (flag),
  .irq       (irq)
);

// File: tb/test_adc_regif.sv
module test_adc_regif;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       trig_evt = 1'b0;
  logic       cnv_start;
  logic       cnv_done = 1'b0;
  logic [9:0] cnv_data = '0;
  logic [3:0] cnv_chan;
  logic [1:0] cnv_ref;
  logic [2:0] clk_div_sel;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  adc_regif i_adc_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_evt(trig_evt), .cnv_start(cnv_start), .cnv_done(cnv_done),
    .cnv_data(cnv_data), .cnv_chan(cnv_chan), .cnv_ref(cnv_ref),
    .clk_div_sel(clk_div_sel), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic finish_conv(input logic [9:0] v);
    @(negedge clk);
    cnv_done = 1'b1; cnv_data = v;
    @(negedge clk);
    cnv_done = 1'b0;
  endtask

  task automatic run_conv(input logic [9:0] v);
    wr(2'd1, 8'hC0);
    finish_conv(v);
  endtask

  function automatic logic [7:0] exp_lo(input int v, input bit left);
    return left ? 8'((v % 4) * 64) : 8'(v % 256);
  endfunction

  function automatic logic [7:0] exp_hi(input int v, input bit left);
    return left ? 8'(v / 4) : 8'(v / 256);
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
        summary();
      end
    end
  end

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'h00, "R1 reg", d, 0);
    end
    check(cnv_start == 0 && irq == 0, "R1 outs", {cnv_start, irq}, 0);
    check(cnv_chan == 0 && cnv_ref == 0 && clk_div_sel == 0, "R1 codes",
          {cnv_chan, cnv_ref, clk_div_sel}, 0);

    // R2 setup sweep
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, 8'(v));
      rd(2'd0, d);
      check(d == 8'(v & 8'hEF), "R2 readback", d, v & 8'hEF);
      check(cnv_ref == 2'(v / 64) && cnv_chan == 4'(v % 16), "R2 outs",
            {cnv_ref, cnv_chan}, {2'(v / 64), 4'(v % 16)});
    end
    wr(2'd0, 8'h00);

    // R3 control readback, R5 no start while disabled
    for (int p = 0; p < 8; p++) begin
      wr(2'd1, 8'h28 | 8'(p));
      check(clk_div_sel == 3'(p), "R3 div", clk_div_sel, p);
      rd(2'd1, d);
      check(d == (8'h28 | 8'(p)), "R3 readback", d, 8'h28 | p);
    end
    wr(2'd1, 8'h60);
    check(cnv_start == 0, "R5 sw start disabled", cnv_start, 0);
    @(negedge clk) trig_evt = 1'b1;
    @(negedge clk);
    check(cnv_start == 0, "R5 trig disabled", cnv_start, 0);
    trig_evt = 1'b0;
    rd(2'd1, d);
    check(d[6] == 0, "R5 not busy", d[6], 0);

    // R4 start pulse, R7 busy ignores starts
    wr(2'd1, 8'hE0);
    check(cnv_start == 1, "R4 pulse", cnv_start, 1);
    @(negedge clk);
    check(cnv_start == 0, "R4 single", cnv_start, 0);
    rd(2'd1, d);
    check(d[6] == 1, "R4 busy", d[6], 1);
    wr(2'd1, 8'hE0);
    check(cnv_start == 0, "R7 sw while busy", cnv_start, 0);
    @(negedge clk) trig_evt = 1'b1;
    @(negedge clk);
    check(cnv_start == 0, "R7 trig while busy", cnv_start, 0);
    trig_evt = 1'b0;
    finish_conv(10'h123);
    rd(2'd1, d);
    check(d[6] == 0, "R4 busy cleared", d[6], 0);
    check(d[4] == 1, "R8 flag set", d[4], 1);
    check(irq == 0, "R9 irq masked", irq, 0);

    // R9 / R8 flag clear semantics
    wr(2'd1, 8'h88);
    check(irq == 1, "R9 irq high", irq, 1);
    rd(2'd1, d);
    check(d[4] == 1, "R8 write 0 keeps flag", d[4], 1);
    wr(2'd1, 8'h98);
    check(irq == 0, "R9 irq low after clear", irq, 0);
    rd(2'd1, d);
    check(d[4] == 0, "R8 write 1 clears", d[4], 0);
    finish_conv(10'h3FF);
    rd(2'd1, d);
    check(d[4] == 0, "R8 idle done ignored", d[4], 0);

    // R6 auto trigger
    wr(2'd1, 8'hA0);
    @(negedge clk) trig_evt = 1'b1;
    @(negedge clk);
    check(cnv_start == 1, "R6 trig start", cnv_start, 1);
    finish_conv(10'h001);
    @(negedge clk);
    check(cnv_start == 0, "R6 level no retrigger", cnv_start, 0);
    trig_evt = 1'b0;
    wr(2'd1, 8'h10);
    rd(2'd2, d); rd(2'd3, d);

    // R10 / R11 exhaustive alignment sweep
    for (int l = 0; l < 2; l++) begin
      wr(2'd0, l ? 8'h20 : 8'h00);
      for (int v = 0; v < 1024; v++) begin
        run_conv(10'(v));
        rd(2'd2, d);
        rd(2'd3, d2);
        if (l == 0) begin
          check(d == exp_lo(v, 0) && d2 == exp_hi(v, 0), "R10 right align",
                {d2, d}, {exp_hi(v, 0), exp_lo(v, 0)});
        end else begin
          check(d == exp_lo(v, 1) && d2 == exp_hi(v, 1), "R11 left align",
                {d2, d}, {exp_hi(v, 1), exp_lo(v, 1)});
        end
      end
    end
    wr(2'd0, 8'h00);

    // R12 freeze
    run_conv(10'h155);
    wr(2'd1, 8'h10);
    rd(2'd2, d);
    check(d == 8'h55, "R12 first lo", d, 8'h55);
    run_conv(10'h2AA);
    rd(2'd1, d);
    check(d[4] == 1, "R12 flag while frozen", d[4], 1);
    rd(2'd3, d);
    check(d == 8'h01, "R12 hi frozen", d, 1);
    rd(2'd2, d);
    check(d == 8'h55, "R12 dropped data", d, 8'h55);
    rd(2'd3, d);
    run_conv(10'h3C3);
    rd(2'd2, d);
    rd(2'd3, d2);
    check(d == 8'hC3 && d2 == 8'h03, "R12 update after unlock", {d2, d}, 16'h03C3);

    // R13 completion colliding with low read
    wr(2'd1, 8'hC0);
    @(negedge clk);
    cnv_done = 1'b1; cnv_data = 10'h0AB;
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 2'd2;
    #1 d = bus_rdata;
    @(negedge clk);
    cnv_done = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0;
    check(d == 8'hC3, "R13 lo old", d, 8'hC3);
    rd(2'd3, d);
    check(d == 8'h03, "R13 hi old", d, 8'h03);
    rd(2'd2, d);
    check(d == 8'hC3, "R13 data dropped", d, 8'hC3);
    rd(2'd3, d);

    summary();
  end

endmodule